// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block gives a debug host a way to read and write system memory without involving a processor. The host sees three registers through a simple strobe-based port: a control/status word, an address register and a data register. Bus traffic is never commanded explicitly. It starts as a side effect of host traffic: writing data launches a bus write, writing the address can launch a bus read, and reading the data register can launch the next read. The data path is a single-outstanding request/ready master with an error response.

Error conditions are sticky. A bus error response and an unsupported access size each leave their own code in a 3-bit error field. A separate flag records host writes to the address or data register that arrive while a transfer is still pending. While either is set, the engine starts no new transfer until the host clears it by writing ones.

The engine is a three-state machine. `S_IDLE` waits for a start. The transition *launch write* goes to `S_WRITE` on a qualified data write, and *launch read* goes to `S_READ` on a qualified read trigger. The transition *complete* returns from either busy state to `S_IDLE` in the cycle the bus returns ready. A start with an unsupported size takes the transition *reject*, which stays in `S_IDLE` and records the size error.

Top module: `dbg_sysbus_ctrl`

## Requirements
- R1: After reset the control word (register 0) reads as version 1 in bits [19:16], the capability mask (bit n set means size code n is supported) in bits [15:11], and zero in every other bit. The address (register 1) and data (register 2) registers read 0 and no bus request is raised.
- R2: A host write to the data register while idle and error-free loads the data and starts exactly one bus write (bus_we=1) of that data to the current address, with bus_size equal to the size code in control bits [5:3].
- R3: With control bit 0 (read on address) set, a qualified host write to the address register loads it and starts a bus read from that address, and the read data lands in the data register. With bit 0 clear, an address write starts nothing.
- R4: With control bit 1 (read on data) set, a host read of the data register returns its current value and then starts a bus read from the current address.
- R5: With control bit 2 (auto-increment) set, the address register advances by 2^size bytes (size codes 0..4 = 1, 2, 4, 8, 16 bytes) after each access that completes without error.
- R6: A bus error response sets the error field (control bits [8:6]) to 2, leaves the data register unchanged and does not advance the address.
- R7: Starting an access while control bits [5:3] hold a size code whose capability bit is clear (or a code of 5 to 7) sets the error field to 3 and issues no bus request.
- R8: The error field clears bit by bit and the busy-violation flag (control bit 9) clears when the host writes 1 to them. Writing 0 to them leaves them unchanged.
- R9: A host write to the address or data register while a transfer is pending sets the busy-violation flag and does not change that register.
- R10: While the error field is nonzero or the busy-violation flag is set, host writes to the address and data registers are ignored and no transfer starts.
- R11: Control bit 10 (busy) is high from the cycle after a transfer is launched until the cycle after the bus returns ready.
- R12: Each started access produces exactly one bus transfer. Its request stays high, with stable address and direction, until ready is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 control, 1 address, 2 data |
| host_wdata | input | XLEN | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on the data register only) |
| host_rdata | output | XLEN | Combinational read data for host_addr |
| bus_req | output | 1 | Bus request, held until bus_ready |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | XLEN | Bus byte address |
| bus_wdata | output | XLEN | Bus write data |
| bus_size | output | 3 | Size code of the pending transfer |
| bus_ready | input | 1 | Transfer complete |
| bus_err | input | 1 | Error response, valid with bus_ready |
| bus_rdata | input | XLEN | Read data, valid with bus_ready |

## Verification
The bench goes after host writes that land in the same cycle window as a pending transfer. A design that sampled busy one cycle late would miss the busy violation, or would overwrite the address while the request is held. It checks that a read triggered by a data-register read returns the old value first, which a design that updated before returning would get wrong. It also checks that a failed transfer neither advances the address nor corrupts the data. Unsupported and out-of-range size codes must be rejected without any bus request, and the sticky flags must block later writes and clear only on written ones, bit by bit.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int NUM_SIZES = 5;

    // control word bit positions
    localparam int B_RDA  = 0;
    localparam int B_RDD  = 1;
    localparam int B_INC  = 2;
    localparam int B_SZ   = 3;
    localparam int B_ERR  = 6;
    localparam int B_VIOL = 9;
    localparam int B_BUSY = 10;
    localparam int B_CAP  = 11;
    localparam int B_VER  = 16;

    localparam logic [3:0] VERSION  = 4'd1;
    localparam logic [2:0] ERR_BUS  = 3'd2;
    localparam logic [2:0] ERR_SIZE = 3'd3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_READ  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_addr;
        logic wr_data;
        logic rd_data;
    } host_ev_t;
endpackage

// File: rtl/sba_host_decode.sv
module sba_host_decode
    import sba_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      host_addr,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [XLEN-1:0] ctrl_word,
    input  logic [XLEN-1:0] addr_q,
    input  logic [XLEN-1:0] data_q,
    output host_ev_t        ev,
    output logic [XLEN-1:0] host_rdata
);
    always_comb begin
        ev.wr_ctrl = host_wr && (host_addr == REG_CTRL);
        ev.wr_addr = host_wr && (host_addr == REG_ADDR);
        ev.wr_data = host_wr && (host_addr == REG_DATA);
        ev.rd_data = host_rd && (host_addr == REG_DATA);
    end

    always_comb begin
        case (host_addr)
            REG_CTRL: host_rdata = ctrl_word;
            REG_ADDR: host_rdata = addr_q;
            REG_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sba_ctrl_regs.sv
module sba_ctrl_regs
    import sba_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl,
    input  logic [B_VIOL:0] wdata,
    input  logic            set_err,
    input  logic [2:0]      err_code,
    input  logic            set_viol,
    output logic            rd_on_addr,
    output logic            rd_on_data,
    output logic            auto_inc,
    output logic [2:0]      sel_size,
    output logic [2:0]      err,
    output logic            viol
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_on_addr <= 1'b0;
            rd_on_data <= 1'b0;
            auto_inc   <= 1'b0;
            sel_size   <= 3'd0;
            err        <= 3'd0;
            viol       <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                rd_on_addr <= wdata[B_RDA];
                rd_on_data <= wdata[B_RDD];
                auto_inc   <= wdata[B_INC];
                sel_size   <= wdata[B_SZ +: 3];
            end
            // a new error wins over a clear in the same cycle
            if (set_err)
                err <= err_code;
            else if (wr_ctrl)
                err <= err & ~wdata[B_ERR +: 3];
            if (set_viol)
                viol <= 1'b1;
            else if (wr_ctrl && wdata[B_VIOL])
                viol <= 1'b0;
        end
    end
endmodule

// File: rtl/sba_size_unit.sv
module sba_size_unit
    import sba_pkg::*;
#(
    parameter int                   XLEN = 32,
    parameter logic [NUM_SIZES-1:0] CAPS = 5'b00111
) (
    input  logic [2:0]      sel_size,
    input  logic [2:0]      acc_size,
    output logic            size_ok,
    output logic [XLEN-1:0] inc_bytes
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic [NUM_SIZES-1:0] hit;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_cap
        assign hit[g] = CAPS[g] && (sel_size == 3'(g));
    end

    assign size_ok   = |hit;
    assign inc_bytes = ONE << acc_size;
endmodule

// File: rtl/sba_engine.sv
module sba_engine
    import sba_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_wr_addr,
    input  logic            ev_wr_data,
    input  logic            ev_rd_data,
    input  logic [XLEN-1:0] wdata,
    input  logic            blocked,
    input  logic            rd_on_addr,
    input  logic            rd_on_data,
    input  logic            auto_inc,
    input  logic [2:0]      sel_size,
    input  logic            size_ok,
    input  logic [XLEN-1:0] inc_bytes,
    output logic [2:0]      acc_size,
    output logic [XLEN-1:0] addr_q,
    output logic [XLEN-1:0] data_q,
    output logic            busy,
    output logic            set_viol,
    output logic            set_err,
    output logic [2:0]      err_code,
    output logic            bus_req,
    output logic            bus_we,
    input  logic            bus_ready,
    input  logic            bus_err,
    input  logic [XLEN-1:0] bus_rdata
);
    eng_state_e state_q, state_d;

    logic idle, open, want_wr, want_rd, size_bad, go_wr, go_rd, done, done_ok;

    always_comb begin
        idle     = (state_q == S_IDLE);
        open     = idle && !blocked;
        want_wr  = open && ev_wr_data;
        want_rd  = open && !ev_wr_data &&
                   ((ev_wr_addr && rd_on_addr) || (ev_rd_data && rd_on_data));
        size_bad = (want_wr || want_rd) && !size_ok;
        go_wr    = want_wr && size_ok;
        go_rd    = want_rd && size_ok;
        done     = !idle && bus_ready;
        done_ok  = done && !bus_err;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (go_wr)      state_d = S_WRITE;   // launch write
                else if (go_rd) state_d = S_READ;    // launch read
            end
            S_WRITE, S_READ: begin
                if (bus_ready)  state_d = S_IDLE;    // complete
            end
            default:            state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        bus_req  = (state_q != S_IDLE);
        bus_we   = (state_q == S_WRITE);
        busy     = (state_q != S_IDLE);
        set_viol = !idle && (ev_wr_addr || ev_wr_data);
        set_err  = size_bad || (done && bus_err);
        err_code = size_bad ? ERR_SIZE : ERR_BUS;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            data_q   <= '0;
            acc_size <= 3'd0;
        end else begin
            if (open && ev_wr_addr)
                addr_q <= wdata;
            else if (done_ok && auto_inc)
                addr_q <= addr_q + inc_bytes;

            if (open && ev_wr_data)
                data_q <= wdata;
            else if (done_ok && (state_q == S_READ))
                data_q <= bus_rdata;

            if (go_wr || go_rd)
                acc_size <= sel_size;
        end
    end
endmodule

// File: rtl/dbg_sysbus_ctrl.sv
module dbg_sysbus_ctrl
    import sba_pkg::*;
#(
    parameter int                   XLEN = 32,
    parameter logic [NUM_SIZES-1:0] CAPS = 5'b00111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      host_addr,
    input  logic [XLEN-1:0] host_wdata,
    input  logic            host_wr,
    input  logic            host_rd,
    output logic [XLEN-1:0] host_rdata,
    output logic            bus_req,
    output logic            bus_we,
    output logic [XLEN-1:0] bus_addr,
    output logic [XLEN-1:0] bus_wdata,
    output logic [2:0]      bus_size,
    input  logic            bus_ready,
    input  logic            bus_err,
    input  logic [XLEN-1:0] bus_rdata
);
    localparam int CTRL_USED = B_VER + 4;

    host_ev_t        ev;
    logic            rda_f, rdd_f, inc_f, viol_f, busy_f;
    logic [2:0]      size_f, err_f, acc_size, err_code;
    logic            set_err, set_viol, size_ok;
    logic [XLEN-1:0] addr_q, data_q, inc_bytes, ctrl_word;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_USED-1:0] = {VERSION, CAPS, busy_f, viol_f, err_f,
                                    size_f, inc_f, rdd_f, rda_f};
    end

    sba_host_decode #(.XLEN(XLEN)) u_dec (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .ctrl_word (ctrl_word),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .ev        (ev),
        .host_rdata(host_rdata)
    );

    sba_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (ev.wr_ctrl),
        .wdata     (host_wdata[B_VIOL:0]),
        .set_err   (set_err),
        .err_code  (err_code),
        .set_viol  (set_viol),
        .rd_on_addr(rda_f),
        .rd_on_data(rdd_f),
        .auto_inc  (inc_f),
        .sel_size  (size_f),
        .err       (err_f),
        .viol      (viol_f)
    );

    sba_size_unit #(.XLEN(XLEN), .CAPS(CAPS)) u_size (
        .sel_size (size_f),
        .acc_size (acc_size),
        .size_ok  (size_ok),
        .inc_bytes(inc_bytes)
    );

    sba_engine #(.XLEN(XLEN)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_wr_addr(ev.wr_addr),
        .ev_wr_data(ev.wr_data),
        .ev_rd_data(ev.rd_data),
        .wdata     (host_wdata),
        .blocked   ((err_f != 3'd0) || viol_f),
        .rd_on_addr(rda_f),
        .rd_on_data(rdd_f),
        .auto_inc  (inc_f),
        .sel_size  (size_f),
        .size_ok   (size_ok),
        .inc_bytes (inc_bytes),
        .acc_size  (acc_size),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .busy      (busy_f),
        .set_viol  (set_viol),
        .set_err   (set_err),
        .err_code  (err_code),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata)
    );

    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
    assign bus_size  = acc_size;
endmodule

// File: rtl/sba_chk.sv
module sba_chk
    import sba_pkg::*;
#(
    parameter int                   XLEN = 32,
    parameter logic [NUM_SIZES-1:0] CAPS = 5'b00111
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      host_addr,
    input logic            host_wr,
    input logic            bus_req,
    input logic            bus_ready,
    input logic            bus_we,
    input logic [XLEN-1:0] bus_addr,
    input logic            busy_f,
    input logic [2:0]      err_f,
    input logic            viol_f,
    input logic [2:0]      size_f
);
    function automatic logic cap_ok(input logic [2:0] s);
        cap_ok = 1'b0;
        for (int i = 0; i < NUM_SIZES; i++)
            if (s == 3'(i) && CAPS[i]) cap_ok = 1'b1;
    endfunction

    logic wr_reg;
    assign wr_reg = host_wr && (host_addr == REG_ADDR || host_addr == REG_DATA);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    p_viol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_f && wr_reg) |=> viol_f);

    p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && (err_f != 3'd0 || viol_f)) |=> !bus_req);

    p_size_rej_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_f && err_f == 3'd0 && !viol_f && host_wr && host_addr == REG_DATA
         && !cap_ok(size_f)) |=> (!bus_req && err_f == ERR_SIZE));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_f != 3'd0 && !(host_wr && host_addr == REG_CTRL)) |=> (err_f == $past(err_f)));

    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> !busy_f);
endmodule

bind dbg_sysbus_ctrl sba_chk #(.XLEN(XLEN), .CAPS(CAPS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .bus_req  (bus_req),
    .bus_ready(bus_ready),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .busy_f   (busy_f),
    .err_f    (err_f),
    .viol_f   (viol_f),
    .size_f   (size_f)
);

// File: tb/dbg_sysbus_ctrl_tb_top.sv
module dbg_sysbus_ctrl_tb_top;
    localparam logic [4:0]  CAPS  = 5'b00111;
    localparam logic [31:0] LIMIT = 32'h100;
    localparam logic [1:0]  RC = 2'd0, RA = 2'd1, RD = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [2:0]  bus_size;
    logic        bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = 32'd0;

    int checks = 0, fails = 0;
    int xfers = 0, exp_xfers = 0, lat = 0;
    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    logic [31:0] last_addr = 0, last_wdata = 0;
    logic        last_we = 0;
    logic [2:0]  last_size = 0;

    dbg_sysbus_ctrl #(.XLEN(32), .CAPS(CAPS)) dut_i (.*);

    always #10 clk = ~clk;

    // bus responder: latency of 0..2 idle negedges, error above LIMIT
    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready <= 1'b0;
            bus_err   <= 1'b0;
        end else if (bus_req) begin
            if (lat == 0) begin
                xfers = xfers + 1;
                last_addr = bus_addr; last_we = bus_we;
                last_wdata = bus_wdata; last_size = bus_size;
                bus_ready <= 1'b1;
                if (bus_addr >= LIMIT) bus_err <= 1'b1;
                else if (bus_we) mem[bus_addr[7:2]] = bus_wdata;
                else bus_rdata <= mem[bus_addr[7:2]];
                lat = xfers % 3;
            end else begin
                lat = lat - 1;
            end
        end
    end

    function automatic logic [31:0] cw(bit rda, bit rdd, bit inc, logic [2:0] sz,
                                       logic [2:0] er, bit vi, bit bz);
        return {12'd0, 4'd1, CAPS, bz, vi, er, sz, inc, rdd, rda};
    endfunction

    function automatic logic [31:0] wv(bit rda, bit rdd, bit inc, logic [2:0] sz,
                                       logic [2:0] er, bit vi);
        return {22'd0, vi, er, sz, inc, rdd, rda};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(logic [1:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [1:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            hread(RC, v);
            if (!v[10]) break;
        end
    endtask

    task automatic bwrite(logic [31:0] a, logic [31:0] d);
        exp_mem[a[7:2]] = d;
        hwrite(RD, d); wait_idle(); exp_xfers++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, a, d;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 64; i++) begin mem[i] = 0; exp_mem[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(RC, v); chk("R1 ctrl", v, cw(0,0,0,0,0,0,0));
        hread(RA, v); chk("R1 addr", v, 0);
        hread(RD, v); chk("R1 data", v, 0);
        chk("R1 req", {31'd0, bus_req}, 0);

        // R3 no read without read-on-address, R2 write, R11 busy
        hwrite(RC, wv(0,0,0,2,0,0));
        hwrite(RA, 32'h10);
        chk("R3 no read", xfers, exp_xfers);
        exp_mem[4] = 32'hA5A5_0001;
        hwrite(RD, 32'hA5A5_0001);
        hread(RC, v); chk("R11 busy high", {31'd0, v[10]}, 1);
        wait_idle(); exp_xfers++;
        chk("R2 we", {31'd0, last_we}, 1);
        chk("R2 addr", last_addr, 32'h10);
        chk("R2 wdata", last_wdata, 32'hA5A5_0001);
        chk("R2 size", {29'd0, last_size}, 2);

        // R3 read on address
        hwrite(RC, wv(1,0,0,2,0,0));
        hwrite(RA, 32'h10); wait_idle(); exp_xfers++;
        hread(RD, v); chk("R3 readback", v, 32'hA5A5_0001);
        chk("R3 dir", {31'd0, last_we}, 0);
        hread(RC, v); chk("R11 busy low", v, cw(1,0,0,2,0,0,0));

        // random writes then random readbacks
        hwrite(RC, wv(0,0,0,2,0,0));
        for (int i = 0; i < 12; i++) begin
            a = ($urandom % 32) << 2; d = $urandom;
            hwrite(RA, a); bwrite(a, d);
        end
        hwrite(RC, wv(1,0,0,2,0,0));
        for (int i = 0; i < 12; i++) begin
            a = ($urandom % 32) << 2;
            hwrite(RA, a); wait_idle(); exp_xfers++;
            hread(RD, v); chk("R3 random", v, exp_mem[a[7:2]]);
        end

        // R5 auto-increment for each supported size
        for (int s = 0; s < 3; s++) begin
            hwrite(RC, wv(0,0,1,3'(s),0,0));
            hwrite(RA, 32'h80);
            for (int k = 0; k < 3; k++) bwrite(32'h80 + 32'(k << s), 32'(k + 1));
            hread(RA, v); chk("R5 advance", v, 32'h80 + 32'(3 << s));
        end

        // R4 read on data
        hwrite(RC, wv(0,0,1,2,0,0));
        hwrite(RA, 32'hC0);
        bwrite(32'hC0, 32'h11); bwrite(32'hC4, 32'h22); bwrite(32'hC8, 32'h33);
        hwrite(RC, wv(0,1,1,2,0,0));
        hwrite(RA, 32'hC0);
        chk("R4 addr write no read", xfers, exp_xfers);
        hread(RD, v); wait_idle(); exp_xfers++; chk("R4 old value", v, 32'h33);
        hread(RD, v); wait_idle(); exp_xfers++; chk("R4 first", v, 32'h11);
        hread(RD, v); wait_idle(); exp_xfers++; chk("R4 second", v, 32'h22);
        hread(RA, v); chk("R5 read advance", v, 32'hCC);

        // R6 bus error
        hwrite(RC, wv(1,0,1,2,0,0));
        hwrite(RA, 32'h200); wait_idle(); exp_xfers++;
        hread(RC, v); chk("R6 err code", v, cw(1,0,1,2,2,0,0));
        hread(RA, v); chk("R6 no advance", v, 32'h200);
        hread(RD, v); chk("R6 data kept", v, 32'h33);

        // R10 blocked by error
        hwrite(RD, 32'h1234); wait_idle();
        chk("R10 no xfer", xfers, exp_xfers);
        hread(RD, v); chk("R10 data kept", v, 32'h33);
        hwrite(RA, 32'h40);
        hread(RA, v); chk("R10 addr kept", v, 32'h200);

        // R8 bitwise write-one clear
        hwrite(RC, wv(1,0,1,2,3'b001,0));
        hread(RC, v); chk("R8 err stays", v, cw(1,0,1,2,2,0,0));
        hwrite(RC, wv(1,0,1,2,3'b010,0));
        hread(RC, v); chk("R8 err cleared", v, cw(1,0,1,2,0,0,0));

        // R7 unsupported sizes
        hwrite(RC, wv(0,0,0,3,0,0));
        hwrite(RD, 32'h55);
        hread(RC, v); chk("R7 size 3", v, cw(0,0,0,3,3,0,0));
        chk("R7 no xfer", xfers, exp_xfers);
        hwrite(RC, wv(0,0,0,7,3'b111,0));
        hwrite(RD, 32'h56);
        hread(RC, v); chk("R7 size 7", v, cw(0,0,0,7,3,0,0));
        chk("R7 no xfer 7", xfers, exp_xfers);
        hwrite(RC, wv(0,0,0,2,3'b111,0));

        // R9 write while busy
        hwrite(RA, 32'h50);
        exp_mem[20] = 32'h77;
        hwrite(RD, 32'h77);
        hwrite(RA, 32'h99);
        wait_idle(); exp_xfers++;
        hread(RC, v); chk("R9 viol set", v, cw(0,0,0,2,0,1,0));
        hread(RA, v); chk("R9 addr kept", v, 32'h50);
        hwrite(RD, 32'h88); wait_idle();
        hread(RD, v); chk("R10 viol blocks", v, 32'h77);
        chk("R10 viol no xfer", xfers, exp_xfers);
        hwrite(RC, wv(0,0,0,2,0,0));
        hread(RC, v); chk("R8 viol 0 write", v, cw(0,0,0,2,0,1,0));
        hwrite(RC, wv(0,0,0,2,0,1));
        hread(RC, v); chk("R8 viol cleared", v, cw(0,0,0,2,0,0,0));
        bwrite(32'h50, 32'h99);
        chk("R2 after clear", last_wdata, 32'h99);

        // R12 one transfer per start
        chk("R12 transfer count", xfers, exp_xfers);
        summary();
    end
endmodule